// File: doc/BRIEF.md
# Eight-Channel DAC Code Register Controller

This block is the digital core that sits between a serial-command decoder and eight converter channels. Each channel keeps two stages. A code register takes new values. An output latch holds the value that actually drives the converter. Codes are written into the first stage and moved to the second stage in one of three ways: by a per-command software load, by a combined write-and-load command, or by a hardware load strobe. The hardware strobe moves all eight channels on the same clock edge, so all outputs change together.

An active-low clear pin forces every output to a programmable default value at once, with no clock edge needed. On the following edges it also writes that default into both stages. At power-on, a strap pin selects whether both stages start at zero scale or at midscale. Each channel also holds a two-bit power-down mode. A watchdog counts idle cycles between accepted commands and raises a sticky interrupt when the programmed timeout runs out.

The command port is a valid/ready stream. `cmd_ready` is low only while the synchronized clear is active. A command offered while `cmd_ready` is low is not taken, and the sender must hold it. The block applies no other back-pressure. A command is accepted on any rising edge where `cmd_valid` and `cmd_ready` are both high.

Top module: `octdac_ctrl`

## Requirements
- R1: While `rst_n` is low, every code register and output latch takes zero when `mid_sel`=0, or midscale (MSB set, all other bits clear) when `mid_sel`=1. The clear default takes the same value, every power-down mode is 00, and `wdog_irq` is 0.
- R2: Opcode 0x1 (write code) changes only the code register of the addressed channel(s). `dac_code` is unchanged.
- R3: Opcode 0x3 (software load) copies the code register into the output latch for the channel at `cmd_addr`, or for all channels when `cmd_all`=1. Other channels are unchanged.
- R4: Opcode 0x2 (write and load) writes the data into both the code register and the output latch of the addressed channel(s) on the accepting edge.
- R5: `ldac_n` passes through a two-flop synchronizer. When it falls between edges, all eight latches take their code registers on the third rising edge after the fall. While it stays low, the latches keep following the code registers.
- R6: Driving `clr_n` low sets every channel of `dac_code` to the clear default with no clock edge. While the clear is synchronized-active, both stages load the default on every edge. The clear ends on the second rising edge after `clr_n` returns high.
- R7: Opcode 0x5 loads the clear default from the data word. The clear default is not changed by a clear.
- R8: `cmd_data` is a 12-bit left-justified word. A channel takes bits [11:12-RES], and the lower bits have no effect.
- R9: Opcode 0x4 sets the addressed channel(s)' mode to `cmd_data[1:0]`, shown at `pd_mode[2c+1:2c]`. The codes are 00 normal, 01 1k to ground, 10 100k to ground, 11 high impedance. A clear leaves the modes unchanged.
- R10: Opcode 0x6 sets the watchdog timeout T to `cmd_data[WD_W-1:0]`, and T=0 disables the watchdog. Every accepted command reloads the counter to T. With T>0, `wdog_irq` rises on the (T+1)th rising edge after the last accepted command.
- R11: Once `wdog_irq` is set, it stays set until an opcode 0x7 (refresh) command is accepted. That command clears it on the accepting edge.
- R12: `cmd_ready` is low while the synchronized clear is active. A command offered at that time has no effect.
- R13: Opcodes 0x0 and 0x8 to 0xF change no code, latch, mode or default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| mid_sel | input | 1 | Power-on value strap: 1 midscale, 0 zero |
| ldac_n | input | 1 | Hardware load strobe, active low, asynchronous |
| clr_n | input | 1 | Clear to default, active low, asynchronous |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | 3 | Channel address |
| cmd_all | input | 1 | Apply to all channels |
| cmd_data | input | 12 | Left-justified data word |
| dac_code | output | 8*RES | Output codes, channel c at [c*RES +: RES] |
| pd_mode | output | 16 | Power-down mode, channel c at [2c+1:2c] |
| wdog_irq | output | 1 | Sticky watchdog timeout interrupt |

## Verification
The bench builds the block with RES=10 and WD_W=8. At 10 bits, the two low data bits that a 10-bit channel drops can differ between writes, which makes the left-justified truncation visible. A 10-bit midscale of 0x200 also separates the power-on strap cases clearly. An 8-bit timeout keeps the watchdog windows short, so the interrupt's rise edge, its stickiness and its reload by traffic can all be timed inside a short run.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
  localparam int NCH   = 8;
  localparam int CH_AW = 3;
  localparam int DIN_W = 12;

  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_WR    = 4'h1,
    OP_WRLD  = 4'h2,
    OP_LOAD  = 4'h3,
    OP_PD    = 4'h4,
    OP_DEF   = 4'h5,
    OP_WDCFG = 4'h6,
    OP_WDREF = 4'h7
  } op_e;
endpackage

// File: rtl/octdac_sync2.sv
// Two-flop synchronizer; asynchronous assertion to INIT, synchronous release.
module octdac_sync2 #(
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic s0;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s0 <= INIT;
      q  <= INIT;
    end else begin
      s0 <= d;
      q  <= s0;
    end
  end
endmodule

// File: rtl/octdac_chan.sv
// One channel: code register feeding an output latch, plus mode bits.
module octdac_chan #(
  parameter int RES = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RES-1:0] por_val,
  input  logic           clr_act,
  input  logic [RES-1:0] dflt,
  input  logic           wr_en,
  input  logic           wrld_en,
  input  logic           ld_en,
  input  logic [RES-1:0] wr_data,
  input  logic           pd_we,
  input  logic [1:0]     pd_in,
  output logic [RES-1:0] lat_q,
  output logic [1:0]     pd_q
);
  logic [RES-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= por_val;
      lat_q  <= por_val;
    end else if (clr_act) begin
      code_q <= dflt;
      lat_q  <= dflt;
    end else begin
      if (wr_en) code_q <= wr_data;
      if (wrld_en)    lat_q <= wr_data;
      else if (ld_en) lat_q <= code_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pd_q <= 2'b00;
    else if (pd_we) pd_q <= pd_in;
  end
endmodule

// File: rtl/octdac_wdog.sv
// Idle-time watchdog: reloaded by every accepted command, sticky interrupt.
module octdac_wdog #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_val,
  input  logic          refresh,
  output logic          irq,
  output logic          en
);
  logic [CW-1:0] lim_q, cnt_q;

  assign en = (lim_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (cfg_we) lim_q <= cfg_val;
      if (kick)               cnt_q <= cfg_we ? cfg_val : lim_q;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      if (refresh)                        irq <= 1'b0;
      else if (en && !kick && cnt_q == '0) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/octdac_ctrl.sv
module octdac_ctrl
  import octdac_pkg::*;
#(
  parameter int RES  = 12,
  parameter int WD_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mid_sel,
  input  logic                 ldac_n,
  input  logic                 clr_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [3:0]           cmd_op,
  input  logic [2:0]           cmd_addr,
  input  logic                 cmd_all,
  input  logic [11:0]          cmd_data,
  output logic [NCH*RES-1:0]   dac_code,
  output logic [2*NCH-1:0]     pd_mode,
  output logic                 wdog_irq
);
  localparam logic [RES-1:0] MID = {1'b1, {(RES-1){1'b0}}};

  logic           clr_act, ld_sync, ld_act, acc, wd_en;
  logic [RES-1:0] por_val, dflt_q, data_r;
  op_e            op;

  assign por_val   = mid_sel ? MID : '0;
  assign cmd_ready = ~clr_act;
  assign acc       = cmd_valid & cmd_ready;
  assign op        = op_e'(cmd_op);
  assign data_r    = cmd_data[DIN_W-1 -: RES];
  assign ld_act    = ~ld_sync;

  octdac_sync2 #(.INIT(1'b1)) u_clr_sync (
    .clk(clk), .arst_n(rst_n & clr_n), .d(1'b0), .q(clr_act)
  );

  octdac_sync2 #(.INIT(1'b1)) u_ld_sync (
    .clk(clk), .arst_n(rst_n), .d(ldac_n), .q(ld_sync)
  );

  // Programmable clear default; starts at the strapped power-on value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    dflt_q <= por_val;
    else if (acc && op == OP_DEF)  dflt_q <= data_r;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic           sel;
    logic [RES-1:0] lat;

    assign sel = cmd_all | (cmd_addr == CH_AW'(ch));

    octdac_chan #(.RES(RES)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .por_val(por_val),
      .clr_act(clr_act),
      .dflt   (dflt_q),
      .wr_en  (acc & sel & (op == OP_WR || op == OP_WRLD)),
      .wrld_en(acc & sel & (op == OP_WRLD)),
      .ld_en  (ld_act | (acc & sel & (op == OP_LOAD))),
      .wr_data(data_r),
      .pd_we  (acc & sel & (op == OP_PD)),
      .pd_in  (cmd_data[1:0]),
      .lat_q  (lat),
      .pd_q   (pd_mode[2*ch +: 2])
    );

    // Clear reaches the output without waiting for a clock edge.
    assign dac_code[ch*RES +: RES] = clr_act ? dflt_q : lat;
  end

  octdac_wdog #(.CW(WD_W)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (acc),
    .cfg_we (acc && op == OP_WDCFG),
    .cfg_val(cmd_data[WD_W-1:0]),
    .refresh(acc && op == OP_WDREF),
    .irq    (wdog_irq),
    .en     (wd_en)
  );
endmodule

module octdac_ctrl_chk #(
  parameter int RES = 12,
  parameter int NCH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [3:0]         cmd_op,
  input logic [NCH*RES-1:0] dac_code,
  input logic [2*NCH-1:0]   pd_mode,
  input logic               wdog_irq,
  input logic               clr_act,
  input logic               ld_act,
  input logic               wd_en
);
  // R6
  clr_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |-> dac_code == {NCH{dac_code[RES-1:0]}});

  // R12
  clr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |-> !cmd_ready);

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_act && !clr_act && !(cmd_valid && cmd_ready)) |=> (clr_act || $stable(dac_code)));

  // R9
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> $stable(pd_mode));

  // R10
  irq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_irq) |-> wd_en);

  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_irq && !(cmd_valid && cmd_ready && cmd_op == 4'h7)) |=> wdog_irq);

  // R11
  irq_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 4'h7) |=> !wdog_irq);
endmodule

bind octdac_ctrl octdac_ctrl_chk #(.RES(RES), .NCH(octdac_pkg::NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .dac_code(dac_code), .pd_mode(pd_mode), .wdog_irq(wdog_irq),
  .clr_act(clr_act), .ld_act(ld_act), .wd_en(wd_en)
);

// File: tb/octdac_ctrl_tb_top.sv
`timescale 1ns/1ps
module octdac_ctrl_tb_top;
  localparam int RES = 10;
  localparam int WD_W = 8;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, mid_sel = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
  logic cmd_valid = 1'b0, cmd_all = 1'b0;
  logic cmd_ready, wdog_irq;
  logic [3:0]  cmd_op = '0;
  logic [2:0]  cmd_addr = '0;
  logic [11:0] cmd_data = '0;
  logic [NC*RES-1:0] dac_code;
  logic [2*NC-1:0]   pd_mode;

  always #2.5 clk = ~clk;

  octdac_ctrl #(.RES(RES), .WD_W(WD_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel), .ldac_n(ldac_n), .clr_n(clr_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_all(cmd_all), .cmd_data(cmd_data),
    .dac_code(dac_code), .pd_mode(pd_mode), .wdog_irq(wdog_irq)
  );

  // Reference model
  logic [RES-1:0] m_code [NC];
  logic [RES-1:0] m_lat  [NC];
  logic [1:0]     m_pd   [NC];
  logic [RES-1:0] m_dflt;
  logic           m_irq, m_rdy;

  typedef struct {
    logic [NC*RES-1:0] d;
    logic [2*NC-1:0]   p;
    logic              i;
    logic              r;
    string             t;
  } exp_t;
  exp_t sb_q[$];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (dac_code !== e.d || pd_mode !== e.p || wdog_irq !== e.i || cmd_ready !== e.r) begin
        errors++;
        $display("FAIL %s: dac=%h pd=%h irq=%b rdy=%b exp dac=%h pd=%h irq=%b rdy=%b",
                 e.t, dac_code, pd_mode, wdog_irq, cmd_ready, e.d, e.p, e.i, e.r);
      end
    end
  end

  task automatic push_exp(input string t);
    exp_t e;
    for (int c = 0; c < NC; c++) begin
      e.d[c*RES +: RES] = m_lat[c];
      e.p[2*c +: 2]     = m_pd[c];
    end
    e.i = m_irq;
    e.r = m_rdy;
    e.t = t;
    sb_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic model_por(input logic mid);
    logic [RES-1:0] v;
    v = mid ? {1'b1, {(RES-1){1'b0}}} : '0;
    for (int c = 0; c < NC; c++) begin
      m_code[c] = v; m_lat[c] = v; m_pd[c] = 2'b00;
    end
    m_dflt = v; m_irq = 1'b0; m_rdy = 1'b1;
  endtask

  task automatic do_reset(input logic mid);
    @(posedge clk); #1;
    rst_n = 1'b0; mid_sel = mid;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    model_por(mid);
  endtask

  task automatic send(input logic [3:0] op, input logic [2:0] a, input logic all,
                      input logic [11:0] d);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_all = all; cmd_data = d;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  initial begin
    do_reset(1'b0);
    push_exp("R1 zero-scale power-on state");

    // R2 / R8: write ch2 with 0xABC -> code 0x2AF, output unchanged
    send(4'h1, 3'd2, 1'b0, 12'hABC);
    m_code[2] = 10'h2AF;
    push_exp("R2 write code leaves output");

    // R3: software load of ch2
    send(4'h3, 3'd2, 1'b0, 12'h000);
    m_lat[2] = m_code[2];
    push_exp("R3 software load single channel");

    // R4 / R8: write-and-load ch5 with 0xABF -> 0x2AF (low bits ignored)
    send(4'h2, 3'd5, 1'b0, 12'hABF);
    m_code[5] = 10'h2AF; m_lat[5] = 10'h2AF;
    push_exp("R4 R8 write-and-load truncation");

    // R3 broadcast load
    send(4'h1, 3'd0, 1'b0, 12'h400);
    m_code[0] = 10'h100;
    send(4'h1, 3'd7, 1'b0, 12'hFFC);
    m_code[7] = 10'h3FF;
    push_exp("R2 two writes, outputs held");
    send(4'h3, 3'd4, 1'b1, 12'h000);
    for (int c = 0; c < NC; c++) m_lat[c] = m_code[c];
    push_exp("R3 broadcast software load");

    // R5: hardware load strobe through synchronizer
    send(4'h1, 3'd1, 1'b0, 12'h004);
    m_code[1] = 10'h001;
    send(4'h1, 3'd3, 1'b0, 12'h008);
    m_code[3] = 10'h002;
    @(posedge clk); #1 ldac_n = 1'b0;
    repeat (2) @(posedge clk);
    #0.5;
    push_exp("R5 latches held before third edge");
    @(posedge clk); #1;
    for (int c = 0; c < NC; c++) m_lat[c] = m_code[c];
    push_exp("R5 simultaneous hardware load");
    ldac_n = 1'b1;
    repeat (3) @(posedge clk);

    // R13: undefined opcode has no effect
    send(4'hF, 3'd0, 1'b1, 12'h123);
    send(4'h0, 3'd0, 1'b1, 12'h456);
    push_exp("R13 undefined opcodes ignored");

    // R9: power-down modes
    send(4'h4, 3'd6, 1'b0, 12'h003);
    m_pd[6] = 2'b11;
    send(4'h4, 3'd0, 1'b0, 12'h002);
    m_pd[0] = 2'b10;
    push_exp("R9 per-channel power-down modes");

    // R7 / R6 / R12: default then asynchronous clear
    send(4'h5, 3'd0, 1'b0, 12'h554);
    m_dflt = 10'h155;
    push_exp("R7 default write not visible");
    @(posedge clk); #1 clr_n = 1'b0;
    for (int c = 0; c < NC; c++) begin m_lat[c] = m_dflt; m_code[c] = m_dflt; end
    m_rdy = 1'b0;
    push_exp("R6 clear forces default without an edge");
    send(4'h2, 3'd0, 1'b0, 12'hFFC);
    push_exp("R12 command during clear ignored");
    @(posedge clk); #1 clr_n = 1'b1;
    @(posedge clk); #1;
    push_exp("R6 clear still active one edge after release");
    @(posedge clk); #1;
    m_rdy = 1'b1;
    push_exp("R12 ready returns on second edge");
    send(4'h3, 3'd0, 1'b1, 12'h000);
    push_exp("R6 code registers hold default; R9 modes kept");

    // R10 / R11: watchdog
    send(4'h6, 3'd0, 1'b0, 12'd20);
    repeat (15) @(posedge clk);
    #1;
    push_exp("R10 no interrupt before timeout");
    repeat (10) @(posedge clk);
    #1;
    m_irq = 1'b1;
    push_exp("R10 interrupt after timeout");
    send(4'h0, 3'd0, 1'b0, 12'h000);
    push_exp("R11 interrupt sticky over other commands");
    send(4'h7, 3'd0, 1'b0, 12'h000);
    m_irq = 1'b0;
    push_exp("R11 refresh clears interrupt");
    for (int k = 0; k < 4; k++) begin
      repeat (10) @(posedge clk);
      send(4'h0, 3'd0, 1'b0, 12'h000);
    end
    push_exp("R10 traffic reloads watchdog");
    send(4'h6, 3'd0, 1'b0, 12'd0);
    repeat (40) @(posedge clk);
    #1;
    push_exp("R10 zero timeout disables watchdog");

    // R1: midscale strap
    do_reset(1'b1);
    push_exp("R1 midscale power-on state");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule